// File: doc/BRIEF.md
# Addressable Asynchronous Serial Port

This block is a full-duplex asynchronous serial port. Each bit on the line lasts `OVS` pulses of a sample tick that the block receives from outside, and no baud generator is included. Frames carry either eight data bits or nine. In the nine-bit format the extra bit marks a frame as an address (1) or as data (0). The transmitter takes a byte and an optional ninth bit on a one-cycle strobe and shifts the frame out on `txd`.

The receiver watches `rxd` for a high-to-low transition. It samples each bit three times around the middle of the bit, takes the majority, and drops a start bit that does not hold low. When the frame ends it reports a stop bit read as 0 as a framing error. With address filtering enabled in nine-bit operation, only address frames reach the host. An address frame must hit the programmed station address under a per-bit don't-care mask, or hit the broadcast address. Received frames are held on a data/valid pair until the host acknowledges them.

Top module: `uart_addr_port`

## Requirements
- R1: `txd` idles at 1. In eight-bit mode (`mode9`=0), a `tx_start` pulse while `tx_busy`=0 sends a 0 start bit, the eight bits of `tx_data` least significant first, and a 1 stop bit. Each bit lasts OVS ticks, and `tx_busy` stays 1 until the stop bit has been sent.
- R2: In nine-bit mode (`mode9`=1), the transmitter inserts `tx_bit9` between the last data bit and the stop bit, giving an 11-bit frame.
- R3: In eight-bit mode, a received frame puts its data byte on `rx_data` and the sampled stop bit on `rx_bit9`.
- R4: In nine-bit mode, a received frame puts its ninth bit on `rx_bit9`.
- R5: Each bit value is the 2-of-3 majority of the samples taken at ticks OVS/2-1, OVS/2 and OVS/2+1 of the bit. If the start bit resolves to 1, the frame is abandoned and the receiver waits for a new falling edge. No data is delivered.
- R6: Every completed frame updates `frame_err`. It reads 1 if the stop bit resolved to 0 and 0 otherwise.
- R7: With `addr_filt_en`=1 and `mode9`=1, frames whose ninth bit is 0 do not assert `rx_valid`.
- R8: With filtering on, an address frame (ninth bit 1) is delivered when every bit at which `addr_mask` is 1 equals the same bit of `own_addr`. Address frames that do not match are dropped.
- R9: With filtering on, an address frame is also delivered when it has a 1 at every bit position where `own_addr | addr_mask` is 1 (the broadcast address).
- R10: `rx_valid` and `rx_data` hold until `rx_ack`. A frame that would be delivered while `rx_valid`=1 and no `rx_ack` is present sets `overrun` and is discarded. `rx_ack` clears both `rx_valid` and `overrun`.
- R11: A `tx_start` pulse while `tx_busy`=1 is ignored: the frame in progress completes unchanged and no second frame follows.
- R12: After reset, `txd`=1 and `tx_busy`, `rx_valid`, `frame_err` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling enable, OVS pulses per bit |
| mode9 | input | 1 | 1 selects nine-bit frames |
| addr_filt_en | input | 1 | Enables address filtering in nine-bit mode |
| own_addr | input | DW | Station address |
| addr_mask | input | DW | Per-bit compare mask, 0 = don't care |
| tx_data | input | DW | Byte to send |
| tx_bit9 | input | 1 | Ninth bit to send in nine-bit mode |
| tx_start | input | 1 | Starts a frame when idle |
| tx_busy | output | 1 | Frame being sent |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_data | output | DW | Received byte |
| rx_bit9 | output | 1 | Ninth bit or stop bit of the held frame |
| rx_valid | output | 1 | Held frame available |
| rx_ack | input | 1 | Host takes the held frame |
| frame_err | output | 1 | Stop bit of last frame read as 0 |
| overrun | output | 1 | Frame lost while one was held |

## Verification
The bench builds the block with its defaults, OVS=16 and DW=8, and pulses `tick` every fourth clock, so one bit spans 64 clocks. At that rate a whole frame takes about 700 cycles, which brings every scenario into a short run: loopback in both frame lengths, a sub-sample start glitch, a bad stop bit, the masked and broadcast address matches, and back-to-back frames that overrun. The default mask value 0xFD leaves a don't-care bit. This lets one run show both a matching and a non-matching address that differ only in bit 0 or bit 1.

// File: rtl/uart_pkg.sv
package uart_pkg;
  typedef enum logic {RX_IDLE = 1'b0, RX_BITS = 1'b1} rx_state_t;

  function automatic logic vote3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction
endpackage

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          mode9,
  input  logic          start,
  input  logic [DW-1:0] data,
  input  logic          bit9,
  output logic          busy,
  output logic          txd
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(OVS);
  localparam int NW = $clog2(FW + 1);

  logic [FW-1:0] sh;
  logic [CW-1:0] tcnt;
  logic [NW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      txd  <= 1'b1;
      sh   <= '1;
      tcnt <= '0;
      left <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        txd  <= 1'b0;
        sh   <= mode9 ? {1'b1, bit9, data, 1'b0} : {2'b11, data, 1'b0};
        left <= mode9 ? NW'(FW) : NW'(FW - 1);
        tcnt <= '0;
      end
    end else if (tick) begin
      if (tcnt == CW'(OVS - 1)) begin
        tcnt <= '0;
        sh   <= {1'b1, sh[FW-1:1]};
        left <= left - 1'b1;
        if (left == NW'(1)) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          txd <= sh[1];
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  // R1
  tx_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !txd));

  // R1
  tx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          mode9,
  input  logic          rxd_in,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          bit9,
  output logic          ferr
);
  localparam int CW = $clog2(OVS);
  localparam int S0 = OVS / 2 - 1;
  localparam int S2 = OVS / 2 + 1;
  localparam int SW = DW + 2;
  localparam int IW = $clog2(DW + 3);

  rx_state_t     state;
  logic [1:0]    sync;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [1:0]    votes;
  logic [SW-1:0] sh;
  logic          m9;
  logic          line_hi;

  logic          rxs;
  logic          bitv;
  logic [SW-1:0] nsh;
  logic          last;

  always_comb begin
    rxs  = sync[1];
    bitv = vote3({votes, rxs});
    nsh  = {bitv, sh[SW-1:1]};
    last = (idx == (m9 ? IW'(DW + 2) : IW'(DW + 1)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync    <= 2'b11;
      state   <= RX_IDLE;
      cnt     <= '0;
      idx     <= '0;
      votes   <= '0;
      sh      <= '0;
      m9      <= 1'b0;
      line_hi <= 1'b0;
      done    <= 1'b0;
      data    <= '0;
      bit9    <= 1'b0;
      ferr    <= 1'b0;
    end else begin
      sync <= {sync[0], rxd_in};
      done <= 1'b0;
      case (state)
        RX_IDLE: if (tick) begin
          if (rxs) begin
            line_hi <= 1'b1;
          end else if (line_hi) begin
            state   <= RX_BITS;
            line_hi <= 1'b0;
            cnt     <= CW'(1);
            idx     <= '0;
            m9      <= mode9;
          end
        end
        RX_BITS: if (tick) begin
          if (cnt >= CW'(S0) && cnt < CW'(S2)) votes <= {votes[0], rxs};
          if (cnt == CW'(S2)) begin
            if (idx == '0) begin
              if (bitv) state <= RX_IDLE;
            end else begin
              sh <= nsh;
              if (last) begin
                state <= RX_IDLE;
                done  <= 1'b1;
                data  <= m9 ? nsh[DW-1:0] : nsh[DW:1];
                bit9  <= m9 ? nsh[DW] : nsh[DW+1];
                ferr  <= !bitv;
              end
            end
          end
          if (cnt == CW'(OVS - 1)) begin
            cnt <= '0;
            idx <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_addr_match.sv
module uart_addr_match #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] rx,
  input  logic [DW-1:0] own,
  input  logic [DW-1:0] mask,
  output logic          hit
);
  logic [DW-1:0] bcast;
  logic          given_hit;
  logic          bcast_hit;

  always_comb begin
    bcast     = own | mask;
    given_hit = ((rx ^ own) & mask) == '0;
    bcast_hit = (rx & bcast) == bcast;
    hit       = given_hit | bcast_hit;
  end
endmodule

// File: rtl/uart_addr_port.sv
module uart_addr_port #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          mode9,
  input  logic          addr_filt_en,
  input  logic [DW-1:0] own_addr,
  input  logic [DW-1:0] addr_mask,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_bit9,
  input  logic          tx_start,
  output logic          tx_busy,
  output logic          txd,
  input  logic          rxd,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          rx_valid,
  input  logic          rx_ack,
  output logic          frame_err,
  output logic          overrun
);
  logic          rdone;
  logic [DW-1:0] rdata;
  logic          rb9;
  logic          rferr;
  logic          hit;
  logic          keep;

  uart_tx #(.OVS(OVS), .DW(DW)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .mode9(mode9), .start(tx_start),
    .data(tx_data), .bit9(tx_bit9), .busy(tx_busy), .txd(txd)
  );

  uart_rx #(.OVS(OVS), .DW(DW)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .mode9(mode9), .rxd_in(rxd),
    .done(rdone), .data(rdata), .bit9(rb9), .ferr(rferr)
  );

  uart_addr_match #(.DW(DW)) u_match (
    .rx(rdata), .own(own_addr), .mask(addr_mask), .hit(hit)
  );

  always_comb keep = !(addr_filt_en && mode9) || (rb9 && hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data   <= '0;
      rx_bit9   <= 1'b0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (rx_ack) begin
        rx_valid <= 1'b0;
        overrun  <= 1'b0;
      end
      if (rdone) begin
        frame_err <= rferr;
        if (keep) begin
          if (rx_valid && !rx_ack) begin
            overrun <= 1'b1;
          end else begin
            rx_data  <= rdata;
            rx_bit9  <= rb9;
            rx_valid <= 1'b1;
          end
        end
      end
    end
  end

  // R7
  filt_pass_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_valid) && $past(addr_filt_en && mode9)) |-> rx_bit9);

  // R10
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ack) |=> (rx_valid && $stable(rx_data)));

  // R10
  overrun_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(rx_valid));
endmodule

// File: tb/tb_uart_addr_port.sv
module tb_uart_addr_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] tdiv = '0;
  logic       mode9 = 1'b0, filt = 1'b0;
  logic [7:0] own = 8'hC0, mask = 8'hFD;
  logic [7:0] tx_data = '0;
  logic       tx_bit9 = 1'b0, tx_start = 1'b0;
  logic       tx_busy, txd;
  logic       loop = 1'b0, drv = 1'b1;
  logic       rxd_w;
  logic [7:0] rx_data;
  logic       rx_bit9, rx_valid, rx_ack = 1'b0, frame_err, overrun;
  int         nchk = 0, nfail = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) begin
    tdiv <= tdiv + 1'b1;
    tick <= (tdiv == 2'd3);
  end

  assign rxd_w = loop ? txd : drv;

  uart_addr_port dut (
    .clk(clk), .rst(rst), .tick(tick), .mode9(mode9), .addr_filt_en(filt),
    .own_addr(own), .addr_mask(mask), .tx_data(tx_data), .tx_bit9(tx_bit9),
    .tx_start(tx_start), .tx_busy(tx_busy), .txd(txd), .rxd(rxd_w),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_valid(rx_valid), .rx_ack(rx_ack),
    .frame_err(frame_err), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); rx_ack = 1'b1;
    @(negedge clk); rx_ack = 1'b0;
  endtask

  task automatic drive_bit(input logic b);
    drv = b; clks(64);
  endtask

  task automatic send_rx(input logic [7:0] d, input logic b9, input logic m9, input logic stopv);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (m9) drive_bit(b9);
    drive_bit(stopv);
    drive_bit(1'b1);
  endtask

  task automatic launch(input logic [7:0] d, input logic b9);
    @(negedge clk); tx_data = d; tx_bit9 = b9; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
  endtask

  task automatic sample_tx(input logic [10:0] exp, input int n, input string req);
    while (txd) @(negedge clk);
    clks(32);
    for (int i = 0; i < n; i++) begin
      chk(txd == exp[i], req, txd, exp[i]);
      clks(64);
    end
    clks(64);
  endtask

  task automatic t_reset();
    chk(txd == 1'b1, "R12 txd", txd, 1);
    chk(tx_busy == 1'b0, "R12 busy", tx_busy, 0);
    chk(rx_valid == 1'b0, "R12 valid", rx_valid, 0);
    chk(frame_err == 1'b0, "R12 ferr", frame_err, 0);
    chk(overrun == 1'b0, "R12 ovr", overrun, 0);
  endtask

  task automatic t_tx8();
    loop = 1'b1; mode9 = 1'b0; filt = 1'b0;
    launch(8'hA5, 1'b0);
    sample_tx({2'b11, 8'hA5, 1'b0}, 10, "R1 tx8 bit");
    chk(tx_busy == 1'b0, "R1 busy end", tx_busy, 0);
    chk(rx_valid && rx_data == 8'hA5, "R3 rx8 data", rx_data, 8'hA5);
    chk(rx_bit9 == 1'b1, "R3 stop in bit9", rx_bit9, 1);
    ack();
  endtask

  task automatic t_tx9();
    loop = 1'b1; mode9 = 1'b1; filt = 1'b0;
    launch(8'h3C, 1'b1);
    sample_tx({1'b1, 1'b1, 8'h3C, 1'b0}, 11, "R2 tx9 bit");
    chk(rx_valid && rx_data == 8'h3C, "R4 rx9 data", rx_data, 8'h3C);
    chk(rx_bit9 == 1'b1, "R4 ninth 1", rx_bit9, 1);
    ack();
    loop = 1'b0;
    send_rx(8'h96, 1'b0, 1'b1, 1'b1);
    chk(rx_valid && rx_data == 8'h96, "R4 rx9 data b", rx_data, 8'h96);
    chk(rx_bit9 == 1'b0, "R4 ninth 0", rx_bit9, 0);
    ack();
  endtask

  task automatic t_busy();
    loop = 1'b1; mode9 = 1'b0; filt = 1'b0;
    launch(8'h11, 1'b0);
    clks(100);
    launch(8'h77, 1'b0);
    clks(620);
    chk(rx_valid && rx_data == 8'h11, "R11 first frame kept", rx_data, 8'h11);
    ack();
    clks(800);
    chk(rx_valid == 1'b0, "R11 no second frame", rx_valid, 0);
    chk(tx_busy == 1'b0, "R11 idle", tx_busy, 0);
  endtask

  task automatic t_false_start();
    loop = 1'b0; mode9 = 1'b0; filt = 1'b0;
    drv = 1'b0; clks(12); drv = 1'b1;
    clks(800);
    chk(rx_valid == 1'b0, "R5 glitch dropped", rx_valid, 0);
    send_rx(8'h5A, 1'b0, 1'b0, 1'b1);
    chk(rx_valid && rx_data == 8'h5A, "R5 after glitch", rx_data, 8'h5A);
    ack();
  endtask

  task automatic t_ferr();
    loop = 1'b0; mode9 = 1'b0; filt = 1'b0;
    send_rx(8'h81, 1'b0, 1'b0, 1'b0);
    chk(frame_err == 1'b1, "R6 bad stop", frame_err, 1);
    chk(rx_bit9 == 1'b0, "R3 stop 0 in bit9", rx_bit9, 0);
    ack();
    send_rx(8'h42, 1'b0, 1'b0, 1'b1);
    chk(frame_err == 1'b0, "R6 good stop", frame_err, 0);
    ack();
  endtask

  task automatic t_filter();
    loop = 1'b0; mode9 = 1'b1; filt = 1'b1; own = 8'hC0; mask = 8'hFD;
    send_rx(8'hC0, 1'b0, 1'b1, 1'b1);
    chk(rx_valid == 1'b0, "R7 data frame dropped", rx_valid, 0);
    send_rx(8'hC2, 1'b1, 1'b1, 1'b1);
    chk(rx_valid && rx_data == 8'hC2, "R8 masked match", rx_data, 8'hC2);
    ack();
    send_rx(8'hC1, 1'b1, 1'b1, 1'b1);
    chk(rx_valid == 1'b0, "R8 mismatch dropped", rx_valid, 0);
    send_rx(8'h40, 1'b1, 1'b1, 1'b1);
    chk(rx_valid == 1'b0, "R8 mismatch high bit", rx_valid, 0);
    send_rx(8'hFD, 1'b1, 1'b1, 1'b1);
    chk(rx_valid && rx_data == 8'hFD, "R9 broadcast", rx_data, 8'hFD);
    ack();
    send_rx(8'hFF, 1'b1, 1'b1, 1'b1);
    chk(rx_valid && rx_data == 8'hFF, "R9 broadcast all ones", rx_data, 8'hFF);
    ack();
    filt = 1'b0;
  endtask

  task automatic t_overrun();
    loop = 1'b0; mode9 = 1'b0; filt = 1'b0;
    send_rx(8'h12, 1'b0, 1'b0, 1'b1);
    chk(overrun == 1'b0, "R10 no overrun yet", overrun, 0);
    send_rx(8'h34, 1'b0, 1'b0, 1'b1);
    chk(overrun == 1'b1, "R10 overrun set", overrun, 1);
    chk(rx_data == 8'h12, "R10 old data kept", rx_data, 8'h12);
    ack();
    chk(rx_valid == 1'b0, "R10 valid cleared", rx_valid, 0);
    chk(overrun == 1'b0, "R10 overrun cleared", overrun, 0);
  endtask

  initial begin
    clks(5);
    rst = 1'b0;
    clks(2);
    t_reset();
    t_tx8();
    t_tx9();
    t_busy();
    t_false_start();
    t_ferr();
    t_filter();
    t_overrun();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule